// File: doc/BRIEF.md
# Modulo Timer with Two Capture/Compare Channels

A 16-bit up-counter that steps on a tick chosen by a 3-bit source select. Codes 0 to 6 divide the bus clock by a power of two. Code 7 counts rising edges of an external clock pin, which is synchronized into the bus-clock domain. When the counter reaches a programmable limit, it returns to zero on the next tick and raises an overflow flag. Each of two channels works on its own either as an input capture unit, which latches the counter on a selected pin edge, or as an output compare unit, which drives its pin when the counter reaches the channel value.

Channel 0 can also run in buffered PWM mode. Channel 0 then drives a pulse that goes high at each overflow and low at the match. The match value comes from one of the two channel value registers. Software writes the register that is not in use, and the pair swaps only at the next overflow, so no period is cut short. The CPU reaches the block through a small word-wide register file with read and write strobes. While the wait input is high, the counter and channels keep running, but every register access is ignored.

Top module: `mtimer`

Register map (3-bit address): 0 control, 1 counter (read only), 2 limit, 3 channel 0 control, 4 channel 0 value, 5 channel 1 control, 6 channel 1 value.

## Requirements
- R1: On each tick the counter increments; when it equals the limit (address 2, reset value 0xFFFF) the tick returns it to 0.
- R2: The overflow flag (control bit 0) sets on the tick that wraps the counter; `irq_ovf_o` is high exactly while that flag and the overflow enable (control bit 1) are both set.
- R3: A flag is cleared only by writing 0 to its bit after a read of the same register returned it as 1; a write of 0 without that prior read leaves the flag set.
- R4: Source select codes 0 to 6 (control bits 6:4) give one tick every 2^code bus clocks, counted from the clear.
- R5: Source select code 7 gives one tick per rising edge of `ext_clk_i`, sampled through a synchronizer.
- R6: Control bit 2 (stop) freezes the counter and the prescaler; writing 1 to control bit 3 zeroes both and reads back as 0.
- R7: In capture mode (channel control bit 2 = 0), the edge field (bits 4:3: 01 rising, 10 falling, 11 both) picks the pin edges that copy the counter into the channel value and set the channel flag (bit 0); an edge that is not selected changes neither.
- R8: In compare mode (bit 2 = 1), the tick that brings the counter to the channel value sets the channel flag and applies the action field (bits 6:5: 01 toggle, 10 drive low, 11 drive high) to `cmp_o`; `irq_ch_o[i]` is high while that flag and the channel enable (bit 1) are both set.
- R9: With channel 0 control bit 7 set, `cmp_o[0]` goes high at each overflow and low at the match with the active value register (channel 0's after the mode is entered). A write to the inactive value register takes effect at the next overflow.
- R10: While `wait_i` is high, register reads return 0, writes change nothing, and the counter keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wait_i | input | 1 | Low-power wait state; locks out register access |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid while rd_i is high |
| ext_clk_i | input | 1 | External count clock |
| cap_i | input | 2 | Capture pins, one per channel |
| cmp_o | output | 2 | Compare output pins, one per channel |
| irq_ovf_o | output | 1 | Overflow interrupt request |
| irq_ch_o | output | 2 | Channel interrupt requests |

## Verification
The hardest state to reach is the buffered value swap. It needs PWM mode, a write to the register that is not in use, and an overflow that falls after that write. The bench reaches it by fixing a short period, measuring the high time over one full period, writing the other register and then measuring again after several periods. A second hard case is the flag-clear handshake, since a counter left running would set the flag again at once. The bench first stops the counter and then tries the write without the read and the write after the read. The prescaler rates are covered by random source codes, limits and run lengths, each stopped and read back against an expected value that the bench computes.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

  // per-channel control fields held in the register file
  typedef struct packed {
    logic       ie;
    logic       cmp;
    logic [1:0] edg;
    logic [1:0] act;
  } ch_cfg_t;

  localparam int unsigned PRE_W = 6;

  // a divided tick falls where the low `ps` prescaler bits are all ones
  function automatic logic pre_tick(logic [PRE_W-1:0] pre, logic [2:0] ps);
    logic [PRE_W-1:0] m;
    m = PRE_W'((7'd1 << ps) - 7'd1);
    return (pre & m) == m;
  endfunction

  // counter value after one tick under limit `lim`
  function automatic logic [15:0] wrap_next(logic [15:0] c, logic [15:0] lim);
    return (c == lim) ? 16'd0 : c + 16'd1;
  endfunction

endpackage

// File: rtl/mt_prescale.sv
module mt_prescale
  import mtimer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] ps,
  input  logic       stop,
  input  logic       clr,
  input  logic       ext_clk_i,
  output logic       tick
);
  logic [PRE_W-1:0] pre;
  logic e1, e2, e3, ext_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      e1 <= 1'b0; e2 <= 1'b0; e3 <= 1'b0;
    end else begin
      e1 <= ext_clk_i;
      e2 <= e1;
      e3 <= e2;
      if (clr)        pre <= '0;
      else if (!stop) pre <= pre + 1'b1;
    end
  end

  assign ext_rise = e2 & ~e3;
  assign tick = !stop && !clr && ((ps == 3'd7) ? ext_rise : pre_tick(pre, ps));
endmodule

// File: rtl/mt_counter.sv
module mt_counter
  import mtimer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          clr,
  input  logic [CW-1:0] lim,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt,
  output logic          ovf_evt
);
  assign cnt_nxt = CW'(wrap_next(16'(cnt), 16'(lim)));
  assign ovf_evt = tick && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (tick) cnt <= cnt_nxt;
  end
endmodule

// File: rtl/mt_channel.sv
module mt_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_i,
  input  logic          tick,
  input  logic          ovf_evt,
  input  logic [CW-1:0] cnt_nxt,
  input  logic          cmp_en,
  input  logic [1:0]    edg,
  input  logic [1:0]    act,
  input  logic          pwm,
  input  logic [CW-1:0] cmp_val,
  output logic          cap_evt,
  output logic          cmp_evt,
  output logic          pin_o
);
  logic s1, s2, s3, rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
    end else begin
      s1 <= pin_i; s2 <= s1; s3 <= s2;
    end
  end

  assign rise    = s2 & ~s3;
  assign fall    = ~s2 & s3;
  assign cap_evt = !cmp_en && ((edg[0] && rise) || (edg[1] && fall));
  assign cmp_evt = cmp_en && tick && (cnt_nxt == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_o <= 1'b0;
    else if (pwm) begin
      if (cmp_evt)      pin_o <= 1'b0;
      else if (ovf_evt) pin_o <= 1'b1;
    end else if (cmp_evt) begin
      case (act)
        2'b01:   pin_o <= ~pin_o;
        2'b10:   pin_o <= 1'b0;
        2'b11:   pin_o <= 1'b1;
        default: pin_o <= pin_o;
      endcase
    end
  end
endmodule

// File: rtl/mtimer.sv
module mtimer
  import mtimer_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NCH = 2,
  parameter int AW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wait_i,
  input  logic [AW-1:0]  addr_i,
  input  logic           wr_i,
  input  logic           rd_i,
  input  logic [CW-1:0]  wdata_i,
  output logic [CW-1:0]  rdata_o,
  input  logic           ext_clk_i,
  input  logic [NCH-1:0] cap_i,
  output logic [NCH-1:0] cmp_o,
  output logic           irq_ovf_o,
  output logic [NCH-1:0] irq_ch_o
);
  localparam logic [AW-1:0] A_CTL = AW'(0);
  localparam logic [AW-1:0] A_CNT = AW'(1);
  localparam logic [AW-1:0] A_LIM = AW'(2);

  function automatic logic [AW-1:0] a_cctl(int i); return AW'(3 + 2*i); endfunction
  function automatic logic [AW-1:0] a_cval(int i); return AW'(4 + 2*i); endfunction

  logic wr_ok, rd_ok, wr_ctl, clr, tick, ovf_evt;
  logic ovf_flag, ovf_ie, stop_q, arm_ovf;
  logic [2:0] ps_q;
  logic [CW-1:0] mod_q, cnt, cnt_nxt;
  ch_cfg_t cfg [NCH];
  logic [NCH-1:0] ch_flag, ch_arm, ch_cap, ch_cmp;
  logic [CW-1:0] ch_val [NCH];
  logic pwm_on, act_sel, pend, wr_inactive;

  assign wr_ok  = wr_i && !wait_i;
  assign rd_ok  = rd_i && !wait_i;
  assign wr_ctl = wr_ok && (addr_i == A_CTL);
  assign clr    = wr_ctl && wdata_i[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_ie <= 1'b0; stop_q <= 1'b0; ps_q <= 3'd0; mod_q <= '1;
    end else begin
      if (wr_ctl) begin
        ovf_ie <= wdata_i[1];
        stop_q <= wdata_i[2];
        ps_q   <= wdata_i[6:4];
      end
      if (wr_ok && addr_i == A_LIM) mod_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0; arm_ovf <= 1'b0;
    end else begin
      if (ovf_evt)                            ovf_flag <= 1'b1;
      else if (wr_ctl && !wdata_i[0] && arm_ovf) ovf_flag <= 1'b0;
      if (rd_ok && addr_i == A_CTL && ovf_flag) arm_ovf <= 1'b1;
      else if (wr_ctl)                          arm_ovf <= 1'b0;
    end
  end

  mt_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .ps(ps_q), .stop(stop_q), .clr(clr),
    .ext_clk_i(ext_clk_i), .tick(tick)
  );

  mt_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr), .lim(mod_q),
    .cnt(cnt), .cnt_nxt(cnt_nxt), .ovf_evt(ovf_evt)
  );

  // buffered pair: channel 0 drives, value registers 0 and 1 alternate
  assign wr_inactive = wr_ok && (addr_i == (act_sel ? a_cval(0) : a_cval(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_on <= 1'b0; act_sel <= 1'b0; pend <= 1'b0;
    end else begin
      if (wr_ok && addr_i == a_cctl(0)) pwm_on <= wdata_i[7];
      if (!pwm_on) begin
        act_sel <= 1'b0; pend <= 1'b0;
      end else if (ovf_evt && pend) begin
        act_sel <= ~act_sel; pend <= 1'b0;
      end else if (wr_inactive) begin
        pend <= 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic wr_c, wr_v, c_en, c_pwm;
    logic [1:0] c_edg;
    logic [CW-1:0] c_val;

    assign wr_c = wr_ok && (addr_i == a_cctl(i));
    assign wr_v = wr_ok && (addr_i == a_cval(i));

    if (i == 0) begin : g_lead
      assign c_en  = cfg[0].cmp | pwm_on;
      assign c_edg = pwm_on ? 2'b00 : cfg[0].edg;
      assign c_pwm = pwm_on;
      assign c_val = (pwm_on && act_sel) ? ch_val[1] : ch_val[0];
    end else if (i == 1) begin : g_partner
      assign c_en  = cfg[1].cmp & ~pwm_on;
      assign c_edg = pwm_on ? 2'b00 : cfg[1].edg;
      assign c_pwm = 1'b0;
      assign c_val = ch_val[1];
    end else begin : g_plain
      assign c_en  = cfg[i].cmp;
      assign c_edg = cfg[i].edg;
      assign c_pwm = 1'b0;
      assign c_val = ch_val[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg[i] <= '0; ch_flag[i] <= 1'b0; ch_arm[i] <= 1'b0; ch_val[i] <= '0;
      end else begin
        if (wr_c) cfg[i] <= '{ie: wdata_i[1], cmp: wdata_i[2],
                              edg: wdata_i[4:3], act: wdata_i[6:5]};
        if (ch_cap[i] || ch_cmp[i])                  ch_flag[i] <= 1'b1;
        else if (wr_c && !wdata_i[0] && ch_arm[i])   ch_flag[i] <= 1'b0;
        if (rd_ok && addr_i == a_cctl(i) && ch_flag[i]) ch_arm[i] <= 1'b1;
        else if (wr_c)                                  ch_arm[i] <= 1'b0;
        if (ch_cap[i])  ch_val[i] <= cnt;
        else if (wr_v)  ch_val[i] <= wdata_i;
      end
    end

    mt_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .pin_i(cap_i[i]), .tick(tick),
      .ovf_evt(ovf_evt), .cnt_nxt(cnt_nxt), .cmp_en(c_en), .edg(c_edg),
      .act(cfg[i].act), .pwm(c_pwm), .cmp_val(c_val),
      .cap_evt(ch_cap[i]), .cmp_evt(ch_cmp[i]), .pin_o(cmp_o[i])
    );

    assign irq_ch_o[i] = ch_flag[i] & cfg[i].ie;
  end

  assign irq_ovf_o = ovf_flag & ovf_ie;

  always_comb begin
    rdata_o = '0;
    if (rd_ok) begin
      case (addr_i)
        A_CTL:   rdata_o[6:0] = {ps_q, 1'b0, stop_q, ovf_ie, ovf_flag};
        A_CNT:   rdata_o = cnt;
        A_LIM:   rdata_o = mod_q;
        default: begin
          for (int i = 0; i < NCH; i++) begin
            if (addr_i == a_cctl(i))
              rdata_o[7:0] = {(i == 0) ? pwm_on : 1'b0, cfg[i].act, cfg[i].edg,
                              cfg[i].cmp, cfg[i].ie, ch_flag[i]};
            if (addr_i == a_cval(i)) rdata_o = ch_val[i];
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mtimer_chk.sv
module mtimer_chk #(
  parameter int CW  = 16,
  parameter int NCH = 2,
  parameter int AW  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wait_i,
  input logic           wr_i,
  input logic [AW-1:0]  addr_i,
  input logic           ovf_evt,
  input logic           ovf_flag,
  input logic           stop_q,
  input logic           clr,
  input logic [CW-1:0]  mod_q,
  input logic [CW-1:0]  cnt,
  input logic [NCH-1:0] ch_cap,
  input logic [NCH-1:0] ch_cmp,
  input logic [NCH-1:0] ch_flag
);
  // R2
  ovf_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag);

  // R6
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !clr) |=> $stable(cnt));

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  // R10
  wait_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_i && wr_i && addr_i == AW'(2)) |=> $stable(mod_q));

  for (genvar i = 0; i < NCH; i++) begin : g_c
    // R7 R8
    ch_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_cap[i] || ch_cmp[i]) |=> ch_flag[i]);
  end
endmodule

bind mtimer mtimer_chk #(.CW(CW), .NCH(NCH), .AW(AW)) u_chk (.*);

// File: tb/mtimer_tb.sv
module mtimer_tb;
  logic clk = 0, rst_n = 0, wait_i = 0, wr_i = 0, rd_i = 0, ext_clk_i = 0;
  logic [2:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic [1:0] cap_i = 0, cmp_o, irq_ch_o;
  logic irq_ovf_o;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  mtimer u_dut (
    .clk(clk), .rst_n(rst_n), .wait_i(wait_i), .addr_i(addr), .wr_i(wr_i),
    .rd_i(rd_i), .wdata_i(wdata), .rdata_o(rdata), .ext_clk_i(ext_clk_i),
    .cap_i(cap_i), .cmp_o(cmp_o), .irq_ovf_o(irq_ovf_o), .irq_ch_o(irq_ch_o)
  );

  function automatic int exp_count(int runs, int ps, int lim);
    return (runs >> ps) % (lim + 1);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_i = 1;
    @(negedge clk); wr_i = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a; rd_i = 1; #1 d = rdata;
    @(negedge clk); rd_i = 0;
  endtask

  task automatic highs(output int n);
    n = 0;
    for (int k = 0; k < 10; k++) begin @(negedge clk); n += int'(cmp_o[0]); end
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state
    rd(0, d); chk("R6 reset control", d, 0);
    rd(2, d); chk("R1 reset limit", d, 16'hFFFF);
    chk("R2 reset irq", {irq_ovf_o, irq_ch_o}, 0);
    chk("R8 reset pins", cmp_o, 0);

    // compare on channel 1: toggle, enabled, value 5
    wr(5, 16'h0026); wr(6, 16'd5);
    wr(0, 16'h0008); repeat (9) @(negedge clk); wr(0, 16'h0004);
    rd(1, d); chk("R1 count after 10 ticks", d, 10);
    chk("R8 toggle on match", cmp_o[1], 1);
    chk("R8 channel irq", irq_ch_o[1], 1);
    rd(5, d); chk("R8 channel flag", d, 16'h0027);

    // capture on channel 0, falling edge only; counter held at 10
    wr(3, 16'h0010);
    cap_i[0] = 1; repeat (6) @(negedge clk);
    rd(3, d); chk("R7 rising ignored flag", d, 16'h0010);
    rd(4, d); chk("R7 rising ignored value", d, 0);
    cap_i[0] = 0; repeat (6) @(negedge clk);
    rd(3, d); chk("R7 falling captured flag", d, 16'h0011);
    rd(4, d); chk("R7 falling captured value", d, 10);
    wr(5, 16'h0008); cap_i[1] = 1; repeat (6) @(negedge clk);
    rd(6, d); chk("R7 rising capture ch1", d, 10);

    // overflow with limit 4
    wr(2, 16'd4); wr(0, 16'h0008); repeat (9) @(negedge clk); wr(0, 16'h0004);
    rd(1, d); chk("R1 wrap to zero", d, 0);
    chk("R2 irq masked", irq_ovf_o, 0);
    rd(0, d); chk("R2 flag set", d, 16'h0005);
    wr(0, 16'h0007); chk("R2 irq enabled", irq_ovf_o, 1);
    wr(0, 16'h0006);
    rd(0, d); chk("R3 write 0 without read keeps flag", d, 16'h0007);
    wr(0, 16'h0006);
    rd(0, d); chk("R3 read then write 0 clears", d, 16'h0006);
    chk("R2 irq drops", irq_ovf_o, 0);

    // external clock source
    wr(2, 16'hFFFF); wr(0, 16'h0078);
    for (int k = 0; k < 7; k++) begin
      ext_clk_i = 1; repeat (3) @(negedge clk);
      ext_clk_i = 0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk); wr(0, 16'h0074);
    rd(1, d); chk("R5 external edges counted", d, 7);

    // random prescale, limit and run length
    for (int it = 0; it < 16; it++) begin
      int ps, dly, lim;
      ps = $urandom % 7; dly = $urandom % 150; lim = 16 + $urandom % 300;
      wr(2, 16'(lim));
      wr(0, 16'((ps << 4) | 8));
      repeat (dly) @(negedge clk);
      wr(0, 16'((ps << 4) | 4));
      rd(1, d); chk("R4 prescaled count", d, exp_count(dly + 1, ps, lim));
    end

    // buffered PWM, period 10
    wr(4, 16'd3); wr(6, 16'd8); wr(2, 16'd9); wr(3, 16'h0080);
    wr(0, 16'h0008); repeat (25) @(negedge clk);
    highs(n); chk("R9 duty from active register", n, 3);
    wr(6, 16'd6); repeat (25) @(negedge clk);
    highs(n); chk("R9 duty after swap", n, 6);

    // wait mode lock-out
    wr(3, 16'h0000); wr(2, 16'hFFFF); wr(0, 16'h0008);
    wait_i = 1; wr(2, 16'd3);
    rd(2, d); chk("R10 read blocked", d, 0);
    repeat (5) @(negedge clk); wait_i = 0; wr(0, 16'h0004);
    rd(1, d); chk("R10 counter ran in wait", d, 8);
    rd(2, d); chk("R10 write ignored", d, 16'hFFFF);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule